// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits on a cartridge between an 8-bit CPU bus and a picture-processor bus. It watches CPU write cycles in the upper half of the CPU address space and keeps eight 8-bit bank registers, a target index and two layout bits. From these it turns each 16-bit CPU address into a program-ROM offset or a work-RAM select, and each 14-bit picture-bus address into a character-memory offset. It also drives the nametable mirroring choice.

All address translation is combinational from the current register state. Only the register file, the layout bits and the mirroring bit are clocked. The ROM and RAM arrays are outside the block, which supplies their offsets and select strobes. The program-ROM size, counted in 8 KB banks, is a parameter. The two fixed program windows are derived from it.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous active-low reset, all eight bank registers, the target index, the program-layout bit and the character-swap bit are zero, and mirroring is vertical (`mirror_horiz` = 0). In this state 0x8000 maps to bank 0, 0xA000 maps to bank 0, 0xC000 maps to bank PRG_BANKS-2 and 0xE000 maps to bank PRG_BANKS-1.
- R2: Only address bits 15:13 and bit 0 are decoded for register writes. A write with bits 15:13 = 100 and bit 0 = 0 is a select write: data bits 2:0 give the target index, bit 6 the program layout and bit 7 the character swap, and data bits 5:3 are ignored. A write with bits 15:13 = 100 and bit 0 = 1 loads the whole data byte into the targeted register. When `cpu_wr` is low, nothing changes.
- R3: The 8 KB program window at 0xE000 always maps to bank PRG_BANKS-1. The window at 0xA000 always maps to register 7.
- R4: With program layout 0, the window at 0x8000 maps to register 6 and the window at 0xC000 maps to bank PRG_BANKS-2. With layout 1, these two assignments swap.
- R5: Registers 6 and 7 are used through their low 6 bits only. For addresses 0x8000–0xFFFF, `prg_rom_sel` is 1 and `prg_rom_offset` = {6-bit bank, cpu_addr[12:0]}.
- R6: Picture addresses 0x0000–0x1FFF form eight 1 KB windows. In the two-bank half, the window pair for register n (n = 0, 1) uses {reg[7:1],0} for its first 1 KB and {reg[7:1],1} for its second. In the other half, windows 0–3 use registers 2–5 unchanged.
- R7: With character swap 0, the two-bank half is 0x0000–0x0FFF. With swap 1, it is 0x1000–0x1FFF. `chr_offset` = {8-bit bank, ppu_addr[9:0]} with `chr_sel` = 1 when ppu_addr[13] = 0. Otherwise `chr_sel` = 0 and `chr_offset` = 0.
- R8: A write with bits 15:13 = 101 and bit 0 = 0 sets `mirror_horiz` from data bit 0, unless `cfg_four_screen` is 1, in which case it is ignored. Writes with bits 15:13 = 101 and bit 0 = 1, and writes to 0xC000–0xFFFF, change no output.
- R9: For addresses 0x6000–0x7FFF, `wram_sel` = 1, `wram_addr` = cpu_addr[12:0], `wram_we` = `cpu_wr`, and `prg_rom_sel` = 0. Writes there leave the bank registers unchanged.
- R10: For addresses below 0x6000, `prg_rom_sel`, `wram_sel` and `wram_we` are 0, and `prg_rom_offset` and `wram_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cfg_four_screen | input | 1 | Cartridge is wired for four-screen mirroring |
| ppu_addr | input | 14 | Picture-bus address |
| prg_rom_sel | output | 1 | Program ROM selected |
| prg_rom_offset | output | 19 | Program ROM byte offset |
| wram_sel | output | 1 | Work RAM selected |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM byte address |
| chr_sel | output | 1 | Character memory selected |
| chr_offset | output | 18 | Character memory byte offset |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
A corrupted bank register, target index or layout bit shows up at the ports in the same cycle that an address falls into a window using that state. The window does not need to be revisited later, because the translation path has no pipeline. A wrong layout bit moves two program windows at once, or both halves of pattern space at once. A wrong target index shows up as the wrong window changing after the data write. The sweeps cover every window under both values of each layout bit, so any such fault appears within one pass of the address sweep.

// File: rtl/mapper_pkg.sv
// Package: shared widths and types for the banked memory mapper.
// Assumes an 8-bit CPU data bus, 8 KB program windows and 1 KB pattern windows.
package mapper_pkg;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 14;
    localparam int DW         = 8;
    localparam int NUM_REGS   = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int PRG_BANK_W = 6;
    localparam int PRG_IN_W   = 13;
    localparam int CHR_BANK_W = DW;
    localparam int CHR_IN_W   = 10;
    localparam int NUM_CHR_RG = 6;

    typedef logic [DW-1:0]                  bank_reg_t;
    typedef logic [NUM_REGS-1:0][DW-1:0]    bank_file_t;
    typedef logic [NUM_CHR_RG-1:0][DW-1:0]  chr_file_t;
endpackage

// File: rtl/mapper_regs.sv
// Module: register file and layout state for the mapper.
// Decodes CPU writes using address bits 15:13 and bit 0 only. Keeps eight
// bank registers, the target index, the two layout bits and the mirroring bit.
// Assumes cpu_wr is high for one cycle per write.
module mapper_regs
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr_top,
    input  logic              addr_odd,
    input  logic [DW-1:0]     data,
    input  logic              four_screen,
    output bank_file_t        bank_file,
    output logic              prg_swap,
    output logic              chr_swap,
    output logic              mirror_h
);
    logic [IDX_W-1:0] target_q;
    logic             sel_wr;
    logic             dat_wr;
    logic             mir_wr;
    logic             unused_data_bits;

    // Decode which register group the current write targets.
    always_comb begin
        sel_wr = wr_en && (addr_top == 3'b100) && !addr_odd;
        dat_wr = wr_en && (addr_top == 3'b100) &&  addr_odd;
        mir_wr = wr_en && (addr_top == 3'b101) && !addr_odd;
    end

    assign unused_data_bits = ^data[5:3];

    // Capture target index and layout bits on select writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            prg_swap <= 1'b0;
            chr_swap <= 1'b0;
        end else if (sel_wr) begin
            target_q <= data[IDX_W-1:0];
            prg_swap <= data[6];
            chr_swap <= data[7];
        end
    end

    // Load the targeted bank register on data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_file <= '0;
        end else if (dat_wr) begin
            bank_file[target_q] <= data;
        end
    end

    // Update mirroring unless the board is hard-wired for four screens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_h <= 1'b0;
        end else if (mir_wr && !four_screen) begin
            mirror_h <= data[0];
        end
    end
endmodule

// File: rtl/mapper_prg_map.sv
// Module: CPU-side address translation.
// Maps 0x8000-0xFFFF onto four 8 KB program windows and 0x6000-0x7FFF onto
// work RAM. Lower addresses select nothing and give zero offsets.
// Assumes PRG_BANKS >= 2.
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 16
) (
    input  logic [CPU_AW-1:0]            cpu_addr,
    input  logic                         cpu_wr,
    input  logic [PRG_BANK_W-1:0]        bank_a,
    input  logic [PRG_BANK_W-1:0]        bank_b,
    input  logic                         prg_swap,
    output logic                         rom_sel,
    output logic [PRG_BANK_W+PRG_IN_W-1:0] rom_off,
    output logic                         ram_sel,
    output logic                         ram_we,
    output logic [PRG_IN_W-1:0]          ram_addr
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);
    localparam logic [PRG_BANK_W-1:0] PENU_BANK = PRG_BANK_W'(PRG_BANKS - 2);

    logic [PRG_BANK_W-1:0] win_bank;

    // Choose the bank for the 8 KB window the address falls in.
    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    win_bank = prg_swap ? PENU_BANK : bank_a;
            2'd1:    win_bank = bank_b;
            2'd2:    win_bank = prg_swap ? bank_a : PENU_BANK;
            default: win_bank = LAST_BANK;
        endcase
    end

    // Drive the ROM and RAM selects and offsets.
    always_comb begin
        rom_sel  = cpu_addr[15];
        ram_sel  = (cpu_addr[15:13] == 3'b011);
        ram_we   = ram_sel && cpu_wr;
        rom_off  = rom_sel ? {win_bank, cpu_addr[PRG_IN_W-1:0]} : '0;
        ram_addr = ram_sel ? cpu_addr[PRG_IN_W-1:0] : '0;
    end
endmodule

// File: rtl/mapper_chr_map.sv
// Module: picture-bus address translation.
// Splits 0x0000-0x1FFF into eight 1 KB windows. One half uses two 2 KB
// pairs and the other uses four single banks. The swap bit picks which half
// is which. Addresses at 0x2000 and above select nothing.
module mapper_chr_map
    import mapper_pkg::*;
(
    input  logic [PPU_AW-1:0]               ppu_addr,
    input  chr_file_t                       chr_regs,
    input  logic                            chr_swap,
    output logic                            chr_sel,
    output logic [CHR_BANK_W+CHR_IN_W-1:0]  chr_off
);
    logic [2:0]            win;
    bank_reg_t             src;
    logic [CHR_BANK_W-1:0] bank;

    // Pick the source register and form the 1 KB bank number.
    always_comb begin
        win = ppu_addr[12:10] ^ {chr_swap, 2'b00};
        if (!win[2]) begin
            src  = chr_regs[{2'b00, win[1]}];
            bank = {src[DW-1:1], win[0]};
        end else begin
            src  = chr_regs[3'd2 + {1'b0, win[1:0]}];
            bank = src;
        end
    end

    // Gate the offset with the pattern-space select.
    always_comb begin
        chr_sel = !ppu_addr[13];
        chr_off = chr_sel ? {bank, ppu_addr[CHR_IN_W-1:0]} : '0;
    end
endmodule

// File: rtl/bank_mapper.sv
// Module: top of the banked memory mapper.
// Connects the register file to the CPU-side and picture-side translators.
// Assumes PRG_BANKS >= 2 and a synchronous active-low reset.
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    input  logic        cfg_four_screen,
    input  logic [13:0] ppu_addr,
    output logic        prg_rom_sel,
    output logic [18:0] prg_rom_offset,
    output logic        wram_sel,
    output logic        wram_we,
    output logic [12:0] wram_addr,
    output logic        chr_sel,
    output logic [17:0] chr_offset,
    output logic        mirror_horiz
);
    bank_file_t bank_file;
    chr_file_t  chr_regs;
    logic       prg_swap_q;
    logic       chr_swap_q;
    logic       unused_hi_bits;

    assign chr_regs       = bank_file[NUM_CHR_RG-1:0];
    assign unused_hi_bits = ^{bank_file[6][7:6], bank_file[7][7:6]};

    mapper_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cpu_wr),
        .addr_top    (cpu_addr[15:13]),
        .addr_odd    (cpu_addr[0]),
        .data        (cpu_data),
        .four_screen (cfg_four_screen),
        .bank_file   (bank_file),
        .prg_swap    (prg_swap_q),
        .chr_swap    (chr_swap_q),
        .mirror_h    (mirror_horiz)
    );

    mapper_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .bank_a   (bank_file[6][PRG_BANK_W-1:0]),
        .bank_b   (bank_file[7][PRG_BANK_W-1:0]),
        .prg_swap (prg_swap_q),
        .rom_sel  (prg_rom_sel),
        .rom_off  (prg_rom_offset),
        .ram_sel  (wram_sel),
        .ram_we   (wram_we),
        .ram_addr (wram_addr)
    );

    mapper_chr_map u_chr (
        .ppu_addr (ppu_addr),
        .chr_regs (chr_regs),
        .chr_swap (chr_swap_q),
        .chr_sel  (chr_sel),
        .chr_off  (chr_offset)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
// Checker: properties of the banked memory mapper, bound into the top.
module bank_mapper_chk #(
    parameter int PRG_BANKS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic        cfg_four_screen,
    input logic [13:0] ppu_addr,
    input logic        prg_rom_sel,
    input logic [18:0] prg_rom_offset,
    input logic        wram_sel,
    input logic        wram_we,
    input logic [12:0] wram_addr,
    input logic        chr_sel,
    input logic [17:0] chr_offset,
    input logic        mirror_horiz,
    input logic        chr_swap
);
    localparam logic [5:0] LAST_BANK = 6'(PRG_BANKS - 1);

    AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_rom_sel && prg_rom_offset[18:13] == LAST_BANK)); // R3

    AST_OFFSET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_sel |-> (prg_rom_offset[12:0] == cpu_addr[12:0])); // R5

    AST_LOW_SPACE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!prg_rom_sel && !wram_sel && !wram_we
                                   && prg_rom_offset == '0 && wram_addr == '0)); // R10

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prg_rom_sel, wram_sel})); // R9

    AST_WRAM_WE: assert property (@(posedge clk) disable iff (!rst_n)
        wram_we |-> (wram_sel && cpu_wr && wram_addr == cpu_addr[12:0])); // R9

    AST_MIRROR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_four_screen)) |-> (mirror_horiz == $past(mirror_horiz))); // R8

    AST_CHR_PAIR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppu_addr[13] && ppu_addr[12] == chr_swap) |-> (chr_offset[10] == ppu_addr[10])); // R6

    AST_CHR_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_addr[13] |-> (!chr_sel && chr_offset == '0)); // R7

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_wr) && $stable(cpu_addr)) |-> $stable(prg_rom_offset)); // R2
endmodule

bind bank_mapper bank_mapper_chk #(.PRG_BANKS(PRG_BANKS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_addr        (cpu_addr),
    .cpu_wr          (cpu_wr),
    .cfg_four_screen (cfg_four_screen),
    .ppu_addr        (ppu_addr),
    .prg_rom_sel     (prg_rom_sel),
    .prg_rom_offset  (prg_rom_offset),
    .wram_sel        (wram_sel),
    .wram_we         (wram_we),
    .wram_addr       (wram_addr),
    .chr_sel         (chr_sel),
    .chr_offset      (chr_offset),
    .mirror_horiz    (mirror_horiz),
    .chr_swap        (chr_swap_q)
);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every program and pattern window under both layout bits.
// Expected offsets come from the requirement arithmetic.
module bank_mapper_tb;
    localparam int PB = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic        cfg_four_screen;
    logic [13:0] ppu_addr;
    logic        prg_rom_sel;
    logic [18:0] prg_rom_offset;
    logic        wram_sel;
    logic        wram_we;
    logic [12:0] wram_addr;
    logic        chr_sel;
    logic [17:0] chr_offset;
    logic        mirror_horiz;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Shadow model of the requirement state.
    logic [7:0] m_reg [8];
    logic       m_prg;
    logic       m_chr;

    always #4 clk = ~clk;

    bank_mapper #(.PRG_BANKS(PB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .cfg_four_screen(cfg_four_screen), .ppu_addr(ppu_addr),
        .prg_rom_sel(prg_rom_sel), .prg_rom_offset(prg_rom_offset),
        .wram_sel(wram_sel), .wram_we(wram_we), .wram_addr(wram_addr),
        .chr_sel(chr_sel), .chr_offset(chr_offset), .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic set_sel(input logic [15:0] a, input int idx, input logic pm, input logic cs);
        bus_wr(a, {cs, pm, 3'b101, 3'(idx)});
        m_prg = pm; m_chr = cs;
    endtask

    task automatic set_reg(input int idx, input logic [7:0] v);
        set_sel(16'h8000 + 16'(idx * 2), idx, m_prg, m_chr);
        bus_wr(16'h9FF1 - 16'(idx * 2), v);
        m_reg[idx] = v;
    endtask

    function automatic logic [18:0] exp_prg(input logic [15:0] a);
        int b;
        case (a[14:13])
            2'd0:    b = m_prg ? PB - 2 : int'(m_reg[6]) % 64;
            2'd1:    b = int'(m_reg[7]) % 64;
            2'd2:    b = m_prg ? int'(m_reg[6]) % 64 : PB - 2;
            default: b = PB - 1;
        endcase
        return 19'(b * 8192 + int'(a[12:0]));
    endfunction

    function automatic logic [17:0] exp_chr(input logic [13:0] p);
        int w, b, pair_base;
        w = int'(p[12:10]);
        pair_base = m_chr ? 4 : 0;
        if (w >= pair_base && w < pair_base + 4) begin
            b = (int'(m_reg[(w - pair_base) / 2]) / 2) * 2 + (w % 2);
        end else begin
            b = int'(m_reg[2 + (w % 4)]);
        end
        return 18'(b * 1024 + int'(p[9:0]));
    endfunction

    task automatic sweep_prg(input string req);
        logic [12:0] offs [4] = '{13'h0000, 13'h0001, 13'h0AAA, 13'h1FFF};
        for (int w = 0; w < 4; w++) begin
            for (int o = 0; o < 4; o++) begin
                @(negedge clk);
                cpu_addr = 16'h8000 + 16'(w * 8192) + 16'(offs[o]);
                #1;
                chk(req, 32'(prg_rom_sel), 32'd1);
                chk(req, 32'(prg_rom_offset), 32'(exp_prg(cpu_addr)));
            end
        end
    endtask

    task automatic sweep_chr(input string req);
        logic [9:0] offs [3] = '{10'h000, 10'h155, 10'h3FF};
        for (int w = 0; w < 8; w++) begin
            for (int o = 0; o < 3; o++) begin
                @(negedge clk);
                ppu_addr = 14'(w * 1024) + 14'(offs[o]);
                #1;
                chk(req, 32'(chr_sel), 32'd1);
                chk(req, 32'(chr_offset), 32'(exp_chr(ppu_addr)));
            end
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0;
        cfg_four_screen = 1'b0; ppu_addr = '0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_prg = 1'b0; m_chr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); #1;
        chk("R1 mirror", 32'(mirror_horiz), 32'd0);
        sweep_prg("R1");
        sweep_chr("R1");

        // R2: register loads through mirrored addresses, ignored select bits
        set_reg(0, 8'h35); set_reg(1, 8'h80); set_reg(2, 8'h11);
        set_reg(3, 8'h22); set_reg(4, 8'h33); set_reg(5, 8'h44);
        set_reg(6, 8'hC5); set_reg(7, 8'hFF);
        sweep_prg("R2");

        // R3 R4 R5: both program layouts
        set_sel(16'h9ABC, 3, 1'b0, 1'b0);
        sweep_prg("R4 layout0");
        set_sel(16'h8002, 3, 1'b1, 1'b0);
        sweep_prg("R4 layout1");
        set_reg(7, 8'h41);
        sweep_prg("R3");
        set_reg(6, 8'h7E);
        sweep_prg("R5");

        // R6 R7: both character layouts, plus upper picture space
        set_sel(16'h8000, 0, m_prg, 1'b0);
        sweep_chr("R6");
        set_sel(16'h8000, 0, m_prg, 1'b1);
        sweep_chr("R7");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ppu_addr = 14'h2000 + 14'(i * 14'h0FFF);
            #1;
            chk("R7 upper sel", 32'(chr_sel), 32'd0);
            chk("R7 upper off", 32'(chr_offset), 32'd0);
        end

        // R8: mirroring control and ignored writes
        bus_wr(16'hA000, 8'h01);
        #1; chk("R8 set horiz", 32'(mirror_horiz), 32'd1);
        bus_wr(16'hBFFE, 8'hFE);
        #1; chk("R8 set vert", 32'(mirror_horiz), 32'd0);
        bus_wr(16'hA001, 8'hFF);
        #1; chk("R8 odd ignored", 32'(mirror_horiz), 32'd0);
        @(negedge clk); cfg_four_screen = 1'b1;
        bus_wr(16'hA000, 8'h01);
        #1; chk("R8 four-screen", 32'(mirror_horiz), 32'd0);
        @(negedge clk); cfg_four_screen = 1'b0;
        bus_wr(16'hC000, 8'hFF); bus_wr(16'hC001, 8'hFF);
        bus_wr(16'hE000, 8'hFF); bus_wr(16'hE001, 8'hFF);
        #1; chk("R8 upper writes", 32'(mirror_horiz), 32'd0);
        sweep_prg("R8");
        sweep_chr("R8");

        // R9: work RAM window
        for (int i = 0; i < 3; i++) begin
            logic [15:0] a;
            a = (i == 0) ? 16'h6000 : (i == 1) ? 16'h7FFF : 16'h6ABC;
            @(negedge clk);
            cpu_addr = a; cpu_wr = 1'b0;
            #1;
            chk("R9 sel", 32'(wram_sel), 32'd1);
            chk("R9 rom off", 32'(prg_rom_sel), 32'd0);
            chk("R9 addr", 32'(wram_addr), 32'(a[12:0]));
            chk("R9 we idle", 32'(wram_we), 32'd0);
            cpu_wr = 1'b1; cpu_data = 8'hA5;
            #1;
            chk("R9 we", 32'(wram_we), 32'd1);
            @(negedge clk); cpu_wr = 1'b0;
        end
        sweep_prg("R9 regs kept");

        // R10: space below the work RAM
        for (int i = 0; i < 4; i++) begin
            logic [15:0] a;
            a = (i == 0) ? 16'h0000 : (i == 1) ? 16'h5FFF : (i == 2) ? 16'h4020 : 16'h2001;
            @(negedge clk);
            cpu_addr = a; cpu_wr = 1'b1; cpu_data = 8'h07;
            #1;
            chk("R10 rom sel", 32'(prg_rom_sel), 32'd0);
            chk("R10 ram sel", 32'(wram_sel), 32'd0);
            chk("R10 we", 32'(wram_we), 32'd0);
            chk("R10 rom off", 32'(prg_rom_offset), 32'd0);
            chk("R10 ram addr", 32'(wram_addr), 32'd0);
            @(negedge clk); cpu_wr = 1'b0;
        end
        sweep_prg("R10 regs kept");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule